// File: doc/BRIEF.md
# Windowed Local-Bus to PCI Address Translator

This block takes a 32-bit address from the local bus and checks it against a set of address windows. Each window has a fixed base and high address, set by parameters. When an address falls inside a window, the block builds a PCI address. The upper bits that stay constant across the window are replaced by the contents of that window's substitution register. The offset bits below them pass through unchanged. The result comes out one clock after the input, together with the window index and a flag that marks the target as PCI memory space or PCI I/O space. An address that hits no window raises a miss output instead.

Each window's substitution register holds exactly as many bits as the window's size leaves constant. A 64 KiB window keeps 16 bits, for example, and a 128-byte window keeps 25 bits. A small write/read port loads and returns these registers, and the bit positions below a register's width always read as zero. A build parameter can remove the registers entirely. In that case every window substitutes a fixed per-window parameter value. Windows are meant not to overlap. If they do, the lowest-numbered window wins.

Top module: `pci_win_xlate`

## Requirements
- R1: After synchronous reset, out_valid, out_miss, out_addr and cfg_rdata are zero, and every substitution register reads back as zero.
- R2: When in_valid is high and in_addr lies within [base, high] of window k (inclusive), then on the next cycle out_valid is 1, out_miss is 0 and out_win equals k.
- R3: On a hit, out_addr takes its top W_k bits from window k's substitution value and its low 32-W_k bits from in_addr. W_k is the number of leading bits on which the window's base and high agree. With 0x56710000 loaded for the window 0x12340000..0x1234FFFF, input 0x12340ABC gives 0x56710ABC.
- R4: On a hit, out_mem equals bit k of the WIN_MEM parameter, where 1 means PCI memory space and 0 means PCI I/O space.
- R5: When in_valid is high and no window contains in_addr, then on the next cycle out_miss is 1, out_valid is 0, and out_addr, out_mem and out_win keep their previous values.
- R6: When in_valid is low, out_valid and out_miss are both 0 on the next cycle.
- R7: A write (cfg_we high) to window cfg_sel stores only the top W_k bits of cfg_wdata and ignores the rest. cfg_rdata shows the substitution value of the window selected on the previous cycle, left-aligned, with every bit below the top W_k forced to zero.
- R8: When a write and a translation through the same window fall in the same cycle, that translation uses the value held before the write. The next translation uses the new value.
- R9: When windows overlap, the lowest-numbered window that contains the address is the one used for out_win, out_addr and out_mem.
- R10: With HAS_SUB_REGS = 0, window k substitutes the top W_k bits of its WIN_FIXED parameter slice. Writes have no effect, and cfg_rdata returns that masked fixed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming address is valid this cycle |
| in_addr | input | 32 | Local-bus address to translate |
| cfg_we | input | 1 | Write strobe for a substitution register |
| cfg_sel | input | WSEL_W | Window index for write and readback |
| cfg_wdata | input | 32 | Write data, left-aligned upper bits |
| cfg_rdata | output | 32 | Registered readback of the selected window |
| out_valid | output | 1 | Translated address valid |
| out_miss | output | 1 | Valid input hit no window |
| out_addr | output | 32 | Translated PCI address |
| out_mem | output | 1 | 1 for PCI memory space, 0 for PCI I/O space |
| out_win | output | WSEL_W | Index of the window that was hit |

## Verification
Two things can happen in the same cycle through the same window: a register write and an address translation. The bench provokes this by raising cfg_we with new data for window 0 in the same cycle as a valid address inside window 0. The output of that cycle must carry the old upper bits. A translation issued right after it must carry the new bits. Both expectations come from a shadow model in the bench that updates only after the write edge. A second instance with overlapping windows and fixed substitution values covers priority and the register-less build.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int ADDR_W = 32;

  // Leading bits on which the window's base and high agree.
  function automatic int const_bits(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] h);
    int  n;
    logic go;
    n  = 0;
    go = 1'b1;
    for (int i = ADDR_W-1; i >= 0; i--) begin
      if (go && (b[i] == h[i])) n++;
      else go = 1'b0;
    end
    return n;
  endfunction

  // Mask with the top w bits set.
  function automatic logic [ADDR_W-1:0] upper_mask(input int w);
    logic [ADDR_W-1:0] m;
    m = '1;
    if (w <= 0) return '0;
    return m << (ADDR_W - w);
  endfunction
endpackage

// File: rtl/xlate_win_decode.sv
`timescale 1ns/1ps
module xlate_win_decode import xlate_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HIGH = '1
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] hit
);
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = WIN_BASE[k*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = WIN_HIGH[k*ADDR_W +: ADDR_W] - BASE;
    logic [ADDR_W-1:0] ofs;
    // Unsigned wrap turns the two-sided range test into one compare.
    assign ofs    = addr - BASE;
    assign hit[k] = (ofs <= SPAN);
  end
endmodule

// File: rtl/xlate_prio_pick.sv
`timescale 1ns/1ps
module xlate_prio_pick #(
  parameter int NUM_WIN = 4,
  parameter int WSEL_W  = 2
) (
  input  logic [NUM_WIN-1:0] hit,
  output logic               any,
  output logic [WSEL_W-1:0]  idx
);
  always_comb begin
    any = |hit;
    idx = '0;
    for (int k = NUM_WIN-1; k >= 0; k--) begin
      if (hit[k]) idx = WSEL_W'(k);
    end
  end

  // R9: the chosen window hits and no lower-numbered window hits
  always_comb begin
    if (any) begin
      assert_pick_lowest_R9: assert (hit[idx] &&
        ((hit & ((NUM_WIN'(1) << idx) - NUM_WIN'(1))) == '0));
    end
  end
endmodule

// File: rtl/xlate_sub_file.sv
`timescale 1ns/1ps
module xlate_sub_file import xlate_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter int WSEL_W  = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE  = '0,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HIGH  = '1,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_FIXED = '0,
  parameter bit HAS_SUB_REGS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WSEL_W-1:0] sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] sub_val [NUM_WIN],
  output logic [ADDR_W-1:0] rdata
);
  logic [ADDR_W-1:0] um [NUM_WIN];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int W = const_bits(WIN_BASE[k*ADDR_W +: ADDR_W], WIN_HIGH[k*ADDR_W +: ADDR_W]);
    assign um[k] = upper_mask(W);
    if (HAS_SUB_REGS) begin : g_reg
      logic [W-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else if (we && (sel == WSEL_W'(k))) r_q <= wdata[ADDR_W-1 -: W];
      end
      assign sub_val[k] = ADDR_W'(r_q) << (ADDR_W - W);
    end else begin : g_fixed
      assign sub_val[k] = WIN_FIXED[k*ADDR_W +: ADDR_W] & upper_mask(W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sub_val[sel];
  end

  // R7: readback never carries bits below the window's constant field
  assert_rdata_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ((rdata & ~um[$past(sel)]) == '0));

  if (HAS_SUB_REGS) begin : g_wr_chk
    // R7: a write lands as the masked upper bits of the data
    assert_write_keeps_upper_R7: assert property (@(posedge clk) disable iff (rst)
      we |=> (sub_val[$past(sel)] == ($past(wdata) & um[$past(sel)])));
  end else begin : g_fix_chk
    // R10: writes leave the fixed substitution untouched
    assert_fixed_ignores_write_R10: assert property (@(posedge clk) disable iff (rst)
      we |=> (sub_val[$past(sel)] == (WIN_FIXED[$past(sel)*ADDR_W +: ADDR_W] & um[$past(sel)])));
  end
endmodule

// File: rtl/pci_win_xlate.sv
`timescale 1ns/1ps
module pci_win_xlate import xlate_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter int WSEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE =
    {32'h0000_0000, 32'hFE00_0000, 32'hABCD_E000, 32'h1234_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HIGH =
    {32'h0000_007F, 32'hFFFF_FFFF, 32'hABCD_FFFF, 32'h1234_FFFF},
  parameter logic [NUM_WIN-1:0] WIN_MEM = 4'b1101,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_FIXED = '0,
  parameter bit HAS_SUB_REGS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              cfg_we,
  input  logic [WSEL_W-1:0] cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              out_valid,
  output logic              out_miss,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_mem,
  output logic [WSEL_W-1:0] out_win
);
  logic [NUM_WIN-1:0] hit_vec;
  logic               any_hit;
  logic [WSEL_W-1:0]  pick;
  logic [ADDR_W-1:0]  sub_val [NUM_WIN];
  logic [ADDR_W-1:0]  umask   [NUM_WIN];
  logic [ADDR_W-1:0]  next_addr;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_mask
    assign umask[k] = upper_mask(const_bits(WIN_BASE[k*ADDR_W +: ADDR_W],
                                            WIN_HIGH[k*ADDR_W +: ADDR_W]));
  end

  xlate_win_decode #(
    .NUM_WIN(NUM_WIN), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH)
  ) u_dec (
    .addr(in_addr), .hit(hit_vec)
  );

  xlate_prio_pick #(
    .NUM_WIN(NUM_WIN), .WSEL_W(WSEL_W)
  ) u_pick (
    .hit(hit_vec), .any(any_hit), .idx(pick)
  );

  xlate_sub_file #(
    .NUM_WIN(NUM_WIN), .WSEL_W(WSEL_W), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH),
    .WIN_FIXED(WIN_FIXED), .HAS_SUB_REGS(HAS_SUB_REGS)
  ) u_subs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .sub_val(sub_val), .rdata(cfg_rdata)
  );

  assign next_addr = (sub_val[pick] & umask[pick]) | (in_addr & ~umask[pick]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
      out_mem   <= 1'b0;
      out_win   <= '0;
    end else begin
      out_valid <= in_valid & any_hit;
      out_miss  <= in_valid & ~any_hit;
      if (in_valid && any_hit) begin
        out_addr <= next_addr;
        out_mem  <= WIN_MEM[pick];
        out_win  <= pick;
      end
    end
  end

  // R5: valid and miss never together
  assert_valid_miss_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_miss));

  // R5: a missed address flags miss and leaves the last translation in place
  assert_miss_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !any_hit) |=> (out_miss && !out_valid && $stable(out_addr)));

  // R6: no request, no response
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_miss));

  // R3: offset bits pass through from the input one cycle earlier
  assert_offset_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_hit) |=> (out_valid &&
      (((out_addr ^ $past(in_addr)) & ~umask[out_win]) == '0)));
endmodule

// File: tb/test_pci_win_xlate.sv
`timescale 1ns/1ps
module test_pci_win_xlate;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, out_addr;
  logic        out_valid, out_miss, out_mem;
  logic [1:0]  out_win;

  pci_win_xlate i_pci_win_xlate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_miss(out_miss), .out_addr(out_addr),
    .out_mem(out_mem), .out_win(out_win)
  );

  // Second build: overlapping windows, fixed substitution
  logic        f_valid = 1'b0;
  logic [31:0] f_addr = '0;
  logic        f_we = 1'b0;
  logic        f_sel = 1'b0;
  logic [31:0] f_wdata = '0;
  logic [31:0] f_rdata, f_oaddr;
  logic        f_ovalid, f_omiss, f_omem;
  logic        f_owin;

  pci_win_xlate #(
    .NUM_WIN(2),
    .WIN_BASE({32'h1000_0000, 32'h1000_0000}),
    .WIN_HIGH({32'h1FFF_FFFF, 32'h10FF_FFFF}),
    .WIN_MEM(2'b10),
    .WIN_FIXED({32'hC000_0000, 32'hA5FF_FFFF}),
    .HAS_SUB_REGS(1'b0)
  ) i_pci_win_xlate_fixed (
    .clk(clk), .rst(rst), .in_valid(f_valid), .in_addr(f_addr),
    .cfg_we(f_we), .cfg_sel(f_sel), .cfg_wdata(f_wdata), .cfg_rdata(f_rdata),
    .out_valid(f_ovalid), .out_miss(f_omiss), .out_addr(f_oaddr),
    .out_mem(f_omem), .out_win(f_owin)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_base [4] = '{32'h1234_0000, 32'hABCD_E000, 32'hFE00_0000, 32'h0000_0000};
  logic [31:0] m_high [4] = '{32'h1234_FFFF, 32'hABCD_FFFF, 32'hFFFF_FFFF, 32'h0000_007F};
  logic        m_mem  [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
  logic [31:0] shadow [4] = '{32'h0, 32'h0, 32'h0, 32'h0};
  logic [31:0] last_addr = '0;
  logic [1:0]  last_win = '0;
  logic        last_mem = 1'b0;

  function automatic int wbits(input logic [31:0] b, input logic [31:0] h);
    logic [32:0] sz;
    sz = {1'b0, h} - {1'b0, b} + 33'd1;
    return 32 - $clog2(sz);
  endfunction

  function automatic logic [31:0] hmask(input int w);
    logic [31:0] m;
    m = '1;
    return (w == 0) ? 32'h0 : (m << (32 - w));
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int k, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 2'(k); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[k] = d & hmask(wbits(m_base[k], m_high[k]));
  endtask

  task automatic rd(input int k, input string tag);
    cfg_sel = 2'(k);
    @(negedge clk);
    chk(tag, cfg_rdata, shadow[k]);
  endtask

  task automatic xl(input logic [31:0] a);
    int hk = -1;
    logic [31:0] m, e;
    for (int k = 3; k >= 0; k--)
      if (a >= m_base[k] && a <= m_high[k]) hk = k;
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    if (hk >= 0) begin
      m = hmask(wbits(m_base[hk], m_high[hk]));
      e = (shadow[hk] & m) | (a & ~m);
      chk("R2 valid", 32'(out_valid), 32'd1);
      chk("R2 win",   32'(out_win), 32'(hk));
      chk("R3 addr",  out_addr, e);
      chk("R4 mem",   32'(out_mem), 32'(m_mem[hk]));
      last_addr = e; last_win = 2'(hk); last_mem = m_mem[hk];
    end else begin
      chk("R5 miss",  32'(out_miss), 32'd1);
      chk("R5 valid", 32'(out_valid), 32'd0);
      chk("R5 hold addr", out_addr, last_addr);
      chk("R5 hold win",  32'(out_win), 32'(last_win));
      chk("R5 hold mem",  32'(out_mem), 32'(last_mem));
    end
  endtask

  task automatic fx(input logic [31:0] a, input logic [31:0] e, input logic ew, input logic em);
    f_valid = 1'b1; f_addr = a;
    @(negedge clk);
    f_valid = 1'b0;
    chk("R9 valid", 32'(f_ovalid), 32'd1);
    chk("R9 win",   32'(f_owin), 32'(ew));
    chk("R10 addr", f_oaddr, e);
    chk("R4 mem fixed", 32'(f_omem), 32'(em));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 out_miss",  32'(out_miss), 32'd0);
    chk("R1 out_addr",  out_addr, 32'd0);
    chk("R1 cfg_rdata", cfg_rdata, 32'd0);
    for (int k = 0; k < 4; k++) rd(k, "R1 reg zero");
    // R6: idle
    @(negedge clk);
    chk("R6 idle valid", 32'(out_valid), 32'd0);
    chk("R6 idle miss",  32'(out_miss), 32'd0);

    // R3: worked example
    wr(0, 32'h5671_0000);
    xl(32'h1234_0ABC);
    chk("R3 example", out_addr, 32'h5671_0ABC);

    // R7: low write bits dropped, readback masked
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h1357_9BDF);
    wr(2, 32'hDEAD_BEEF);
    wr(3, 32'h89AB_CDEF);
    for (int k = 0; k < 4; k++) rd(k, "R7 readback");
    chk("R7 w1 value", shadow[1], 32'h1357_8000);
    chk("R7 w2 value", shadow[2], 32'hDE00_0000);
    chk("R7 w3 value", shadow[3], 32'h89AB_CD80);

    // R2/R3/R4/R5: edges of every window and just outside
    for (int k = 0; k < 4; k++) begin
      xl(m_base[k]);
      xl(m_high[k]);
      xl(m_base[k] + ((m_high[k] - m_base[k]) >> 1));
      xl(m_base[k] - 32'd1);
      xl(m_high[k] + 32'd1);
    end
    // exhaustive over the small window and beyond it
    for (int a = 0; a < 160; a++) xl(32'(a));
    // stride across window 1 and its neighbours
    for (int i = 0; i < 48; i++) xl(32'hABCD_D000 + 32'(i) * 32'h100);
    xl(32'h5000_0000);
    // R6: idle after a hit drops valid
    xl(32'h1234_5678);
    @(negedge clk);
    chk("R6 idle after hit", 32'(out_valid), 32'd0);

    // R8: write and translate the same window in the same cycle
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0BAD_0000;
    in_valid = 1'b1; in_addr = 32'h1234_1111;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R8 old value used", out_addr, (shadow[0] & 32'hFFFF_0000) | 32'h0000_1111);
    shadow[0] = 32'h0BAD_0000;
    xl(32'h1234_1111);
    chk("R8 new value used", out_addr, 32'h0BAD_1111);

    // R9/R10: overlapping fixed windows
    fx(32'h1012_3456, 32'hA512_3456, 1'b0, 1'b0);
    fx(32'h1234_5678, 32'hC234_5678, 1'b1, 1'b1);
    f_we = 1'b1; f_sel = 1'b0; f_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    f_we = 1'b0;
    fx(32'h10FF_FFFF, 32'hA5FF_FFFF, 1'b0, 1'b0);
    f_sel = 1'b0;
    @(negedge clk);
    chk("R10 readback win0", f_rdata, 32'hA500_0000);
    f_sel = 1'b1;
    @(negedge clk);
    chk("R10 readback win1", f_rdata, 32'hC000_0000);
    f_valid = 1'b1; f_addr = 32'h2000_0000;
    @(negedge clk);
    f_valid = 1'b0;
    chk("R5 fixed miss", 32'(f_omiss), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule